// File: doc/BRIEF.md
# Periodic Rate and Interrupt Flag Unit

This block sits beside the timekeeping logic of a real-time clock. A free-running binary divider, advanced by one tick per period of a 32.768 kHz reference, feeds a rate selector. A 4-bit rate code picks one divider output. That output drives a square-wave pin, and its rising edges set a periodic event flag. The rate code is held in a register that reset does not touch.

Three event flags are kept in a status byte that clears when it is read. The flags are periodic, alarm and update-ended. Alarm and update-ended events arrive as one-cycle pulses from outside the block. Each flag has an enable bit. An interrupt request, active low, is driven whenever a set flag has its enable set, and a summary bit in the status byte shows the same condition.

A status read spans one or more cycles on a read strobe. The byte is frozen at the start of the read. The flags are cleared when the read ends. Events that land during the read are held back and posted once it completes, so none is lost.

Top module: `rtc_rate_irq`

## Requirements
- R1: Rate code 0 selects no tap: the square wave stays low and the periodic flag is never set.
- R2: Code 1 gives a square-wave period of 128 ticks (256 Hz) and code 2 gives 256 ticks (128 Hz).
- R3: Codes 3 to 15 give a period of 2^(code-1) ticks, from 4 ticks (8.192 kHz) to 16384 ticks (2 Hz).
- R4: The periodic flag is set on each rising edge of the selected tap, whether or not its enable is set.
- R5: Status byte layout: bit 7 summary (IRQF), bit 6 periodic, bit 5 alarm, bit 4 update-ended; bits 3 to 0 read 0.
- R6: irq_no is low exactly when a flag and its enable are both set. Enabling a flag that is already set pulls irq_no low on the next cycle.
- R7: During a read, status_o shows the byte captured when the strobe rose. All flags and the summary bit are clear in the cycle after the strobe falls.
- R8: An event that arrives while the strobe is high is not lost: its flag is set once the read completes.
- R9: Reset low clears the three enables, the square-wave enable and all flags, and it leaves the rate code unchanged.
- R10: While the square-wave enable is 0, sqw_o is held low.
- R11: A control write with the SET bit (ctrl_i[4]) at 1 clears the update-ended enable, whatever value is written to ctrl_i[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One pulse per 32.768 kHz period; advances the divider |
| rate_we_i | input | 1 | Load rate_i into the rate register |
| rate_i | input | 4 | Rate code |
| ctrl_we_i | input | 1 | Load the control bits |
| ctrl_i | input | 5 | [4] SET, [3] periodic enable, [2] alarm enable, [1] update enable, [0] square-wave enable |
| alarm_ev_i | input | 1 | Alarm match pulse |
| update_ev_i | input | 1 | Update-ended pulse |
| stat_rd_i | input | 1 | Status read strobe, high for the whole read |
| status_o | output | 8 | Status byte |
| irq_no | output | 1 | Interrupt request, active low |
| sqw_o | output | 1 | Square-wave output |

## Verification
The bench uses the default parameters: a 15-stage divider and a 4-bit rate code. It asserts the tick on every clock, so one tick equals one clock cycle. Under these settings, even the slowest 2 Hz tap completes several full periods within the run. The square-wave period is measured for all fifteen non-zero codes, covering both low-code aliases and every octave. The bench also covers deferring an alarm pulse that lands inside a read, and shows that reset keeps the rate code.

// File: rtl/rtc_rate_irq_pkg.sv
package rtc_rate_irq_pkg;

  typedef struct packed {
    logic pie;
    logic aie;
    logic uie;
    logic sqwe;
  } irq_en_t;

  // flag vector order inside the block
  localparam int unsigned FL_PF = 2;
  localparam int unsigned FL_AF = 1;
  localparam int unsigned FL_UF = 0;
  localparam int unsigned NUM_FLAGS = 3;

  // control word fields
  localparam int unsigned CW_SET  = 4;
  localparam int unsigned CW_PIE  = 3;
  localparam int unsigned CW_AIE  = 2;
  localparam int unsigned CW_UIE  = 1;
  localparam int unsigned CW_SQWE = 0;
  localparam int unsigned CW_W    = 5;

  // divider counter bit carrying the tap for a rate code (code 0 unused)
  function automatic int unsigned tap_bit(input int unsigned code);
    if (code == 1)      return 6;
    else if (code == 2) return 7;
    else                return code - 2;
  endfunction

endpackage

// File: rtl/rtc_rate_ctrl.sv
module rtc_rate_ctrl
  import rtc_rate_irq_pkg::*;
#(
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ctrl_we_i,
  input  logic [CW_W-1:0]   ctrl_i,
  output logic [RATE_W-1:0] rate_o,
  output irq_en_t           en_o
);

  logic [RATE_W-1:0] rate_q;
  irq_en_t           en_q;

  // rate code deliberately survives reset
  always_ff @(posedge clk_i) begin
    if (rate_we_i) rate_q <= rate_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (ctrl_we_i) begin
      en_q.pie  <= ctrl_i[CW_PIE];
      en_q.aie  <= ctrl_i[CW_AIE];
      en_q.uie  <= ctrl_i[CW_UIE] & ~ctrl_i[CW_SET];
      en_q.sqwe <= ctrl_i[CW_SQWE];
    end
  end

  assign rate_o = rate_q;
  assign en_o   = en_q;

endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider
  import rtc_rate_irq_pkg::*;
#(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              sqwe_i,
  output logic              sqw_o,
  output logic              per_pulse_o
);

  // last stage (1 Hz) feeds the update chain elsewhere; not tapped here
  localparam int unsigned CNT_W     = DIV_W - 1;
  localparam int unsigned NUM_CODES = 1 << RATE_W;

  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_CODES-1:0] taps;
  logic                 tap_d, tap_q, sqw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (osc_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_tap
    if (c == 0) begin : g_off
      assign taps[c] = 1'b0;
    end else begin : g_on
      assign taps[c] = cnt_q[tap_bit(c)];
    end
  end

  assign tap_d = taps[rate_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q <= 1'b0;
      sqw_q <= 1'b0;
    end else begin
      tap_q <= tap_d;
      sqw_q <= tap_d & sqwe_i;
    end
  end

  assign per_pulse_o = tap_d & ~tap_q;
  assign sqw_o       = sqw_q;

endmodule

// File: rtl/rtc_flag_status.sv
module rtc_flag_status
  import rtc_rate_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] ev_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  input  logic                 rd_i,
  output logic [7:0]           status_o,
  output logic                 irq_no,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 busy_o
);

  logic [NUM_FLAGS-1:0] flags_q, pend_q;
  logic [7:0]           snap_q, live_byte;
  logic                 busy_q, irqf;

  assign irqf      = |(flags_q & en_i);
  assign live_byte = {irqf, flags_q, 4'b0000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      pend_q  <= '0;
      snap_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= rd_i;
      if (rd_i && !busy_q) snap_q <= live_byte;
      if (rd_i) begin
        pend_q <= pend_q | ev_i;          // defer while read is open
      end else if (busy_q) begin
        flags_q <= pend_q | ev_i;         // read closed: clear, then post
        pend_q  <= '0;
      end else begin
        flags_q <= flags_q | ev_i;
      end
    end
  end

  assign status_o = busy_q ? snap_q : live_byte;
  assign irq_no   = ~irqf;
  assign flags_o  = flags_q;
  assign busy_o   = busy_q;

endmodule

// File: rtl/rtc_rate_irq.sv
module rtc_rate_irq
  import rtc_rate_irq_pkg::*;
#(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ctrl_we_i,
  input  logic [CW_W-1:0]   ctrl_i,
  input  logic              alarm_ev_i,
  input  logic              update_ev_i,
  input  logic              stat_rd_i,
  output logic [7:0]        status_o,
  output logic              irq_no,
  output logic              sqw_o
);

  logic [RATE_W-1:0]    rate;
  irq_en_t              en;
  logic                 per_pulse;
  logic [NUM_FLAGS-1:0] ev, en_vec, flags;
  logic                 busy;

  rtc_rate_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_we_i (rate_we_i),
    .rate_i    (rate_i),
    .ctrl_we_i (ctrl_we_i),
    .ctrl_i    (ctrl_i),
    .rate_o    (rate),
    .en_o      (en)
  );

  rtc_rate_divider #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .osc_tick_i  (osc_tick_i),
    .rate_i      (rate),
    .sqwe_i      (en.sqwe),
    .sqw_o       (sqw_o),
    .per_pulse_o (per_pulse)
  );

  always_comb begin
    ev             = '0;
    ev[FL_PF]      = per_pulse;
    ev[FL_AF]      = alarm_ev_i;
    ev[FL_UF]      = update_ev_i;
    en_vec         = '0;
    en_vec[FL_PF]  = en.pie;
    en_vec[FL_AF]  = en.aie;
    en_vec[FL_UF]  = en.uie;
  end

  rtc_flag_status u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .en_i     (en_vec),
    .rd_i     (stat_rd_i),
    .status_o (status_o),
    .irq_no   (irq_no),
    .flags_o  (flags),
    .busy_o   (busy)
  );

endmodule

// File: rtl/rtc_rate_irq_chk.sv
module rtc_rate_irq_chk
  import rtc_rate_irq_pkg::*;
#(
  parameter int unsigned RATE_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 stat_rd_i,
  input logic                 busy,
  input logic [NUM_FLAGS-1:0] flags,
  input irq_en_t              en,
  input logic                 per_pulse,
  input logic [RATE_W-1:0]    rate,
  input logic                 sqw_o,
  input logic                 irq_no,
  input logic                 ctrl_we_i,
  input logic [CW_W-1:0]      ctrl_i
);

  a_r1_idle_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate == '0) |-> !per_pulse);

  a_r4_pf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_pulse && !stat_rd_i && !busy) |=> flags[FL_PF]);

  a_r6_enable_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en.aie) && flags[FL_AF]) |-> !irq_no);

  a_r6_quiet_when_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == '0) |-> irq_no);

  a_r8_hold_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> $stable(flags));

  a_r10_sqw_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en.sqwe |=> !sqw_o);

  a_r11_set_clears_uie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_i[CW_SET]) |=> !en.uie);

endmodule

bind rtc_rate_irq rtc_rate_irq_chk #(.RATE_W(RATE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stat_rd_i (stat_rd_i),
  .busy      (busy),
  .flags     (flags),
  .en        (en),
  .per_pulse (per_pulse),
  .rate      (rate),
  .sqw_o     (sqw_o),
  .irq_no    (irq_no),
  .ctrl_we_i (ctrl_we_i),
  .ctrl_i    (ctrl_i)
);

// File: tb/test_rtc_rate_irq.sv
module test_rtc_rate_irq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  localparam int K_STATUS = 0;
  localparam int K_IRQ    = 1;
  localparam int K_SQW    = 2;
  localparam int K_PERIOD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_we = 1'b0;
  logic [3:0] rate = 4'd0;
  logic       ctrl_we = 1'b0;
  logic [4:0] ctrl = 5'd0;
  logic       alarm_ev = 1'b0;
  logic       update_ev = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] status;
  logic       irq_n;
  logic       sqw;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_rate_irq i_rtc_rate_irq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .osc_tick_i  (1'b1),
    .rate_we_i   (rate_we),
    .rate_i      (rate),
    .ctrl_we_i   (ctrl_we),
    .ctrl_i      (ctrl),
    .alarm_ev_i  (alarm_ev),
    .update_ev_i (update_ev),
    .stat_rd_i   (stat_rd),
    .status_o    (status),
    .irq_no      (irq_n),
    .sqw_o       (sqw)
  );

  typedef struct {
    string tag;
    int    kind;
    int    exp;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // period monitor, sampled on falling edges
  int cyc = 0, last_rise = 0, meas = 0;
  logic sqw_prev = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sqw && !sqw_prev) begin
      meas      <= cyc - last_rise;
      last_rise <= cyc;
    end
    sqw_prev <= sqw;
  end

  // scoreboard monitor
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      #1;
      begin
        item_t it;
        int    act;
        it = exp_q.pop_front();
        case (it.kind)
          K_STATUS: act = int'(status);
          K_IRQ:    act = int'(irq_n);
          K_SQW:    act = int'(sqw);
          default:  act = meas;
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string tag, input int kind, input int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    #2;
  endtask

  task automatic set_rate(input logic [3:0] r);
    @(negedge clk); rate = r; rate_we = 1'b1;
    @(negedge clk); rate_we = 1'b0;
  endtask

  task automatic set_ctrl(input logic [4:0] c);
    @(negedge clk); ctrl = c; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_ev = 1'b1;
    @(negedge clk); alarm_ev = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_ev = 1'b1;
    @(negedge clk); update_ev = 1'b0;
  endtask

  // simple read: returns after the cycle in which flags were cleared
  task automatic do_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    @(negedge clk);
  endtask

  function automatic int period_of(input int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 1 << (code - 1);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rate_we = 1'b1; rate = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; rate_we = 1'b0;
    @(negedge clk);
    expect_val("R9 reset status", K_STATUS, 8'h00);
    expect_val("R9 reset irq", K_IRQ, 1);
    expect_val("R9 reset sqw", K_SQW, 0);

    // R1: code 0 with square wave enabled
    set_ctrl(5'b00001);
    for (int i = 0; i < 6; i++) begin
      repeat (37) @(negedge clk);
      expect_val("R1 sqw low on code 0", K_SQW, 0);
    end
    expect_val("R1 no periodic flag", K_STATUS, 8'h00);

    // R10: fast tap but square wave disabled
    set_ctrl(5'b00000);
    set_rate(4'd3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      expect_val("R10 sqw held low", K_SQW, 0);
    end

    // R4 + R5: PF set without PIE, summary bit stays 0
    set_rate(4'd0);
    do_read();
    expect_val("R7 cleared after read", K_STATUS, 8'h00);
    set_rate(4'd3);
    repeat (8) @(negedge clk);
    expect_val("R4 R5 PF bit 6 only", K_STATUS, 8'h40);
    expect_val("R4 no irq without enable", K_IRQ, 1);
    set_ctrl(5'b01000);
    expect_val("R6 R5 PF with PIE", K_STATUS, 8'hC0);
    expect_val("R6 irq with PIE", K_IRQ, 0);
    set_rate(4'd0);
    set_ctrl(5'b00000);
    do_read();
    expect_val("R7 PF cleared", K_STATUS, 8'h00);

    // R8: alarm during read is deferred
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); alarm_ev = 1'b1;
    expect_val("R7 snapshot during read", K_STATUS, 8'h00);
    @(negedge clk); alarm_ev = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
    expect_val("R8 deferred alarm posted", K_STATUS, 8'h20);
    expect_val("R8 alarm not enabled", K_IRQ, 1);
    // R6: enable after flag set
    @(negedge clk); ctrl = 5'b00100; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
    expect_val("R6 immediate irq on enable", K_IRQ, 0);
    expect_val("R6 R5 summary with AF", K_STATUS, 8'hA0);
    // R7: snapshot held, then cleared
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b1;
    expect_val("R7 snapshot AF", K_STATUS, 8'hA0);
    expect_val("R7 irq held during read", K_IRQ, 0);
    @(negedge clk); stat_rd = 1'b0;
    @(negedge clk);
    expect_val("R7 flags cleared", K_STATUS, 8'h00);
    expect_val("R7 irq released", K_IRQ, 1);

    // R11: SET clears UIE
    set_ctrl(5'b00010);
    pulse_update();
    expect_val("R6 update irq", K_STATUS, 8'h90);
    set_ctrl(5'b10010);
    expect_val("R11 UIE cleared by SET", K_STATUS, 8'h10);
    expect_val("R11 irq released", K_IRQ, 1);
    do_read();

    // R2 / R3: period sweep
    set_ctrl(5'b00001);
    for (int c = 1; c < 16; c++) begin
      set_rate(4'(c));
      repeat (3 * period_of(c) + 4) @(negedge clk);
      expect_val(c < 3 ? "R2 alias period" : "R3 octave period", K_PERIOD, period_of(c));
    end

    // R9: reset clears enables and flags, keeps rate
    set_rate(4'd5);
    set_ctrl(5'b01111);
    pulse_alarm();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expect_val("R9 flags cleared", K_STATUS, 8'h00);
    expect_val("R9 irq released", K_IRQ, 1);
    expect_val("R9 sqw low", K_SQW, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    expect_val("R9 SQWE cleared", K_SQW, 0);
    pulse_alarm();
    expect_val("R9 AIE cleared", K_IRQ, 1);
    set_ctrl(5'b00001);
    repeat (3 * 16 + 4) @(negedge clk);
    expect_val("R9 rate kept", K_PERIOD, 16);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule